// File: doc/BRIEF.md
# Integer/FP Dual-Issue Pairing Logic

This block sits at the head of an in-order instruction queue and decides, in every cycle, whether to issue the two oldest queued instructions together or only the oldest one. Both entries arrive already decoded: a valid bit, an instruction class (integer or floating-point), a subclass for the integer-side slot, and register indices. Two instructions issue together only when the older one is integer and the younger one is floating-point, and only when the pair is free of the two hazards the block detects.

The first hazard is a port clash. An integer-slot instruction that moves data into or out of the floating-point register file (an FP load, an FP store or a move between the register sets) competes with the FP instruction for the FP register-file ports. The FP instruction is then held for one cycle. The parameter `EXTRA_FP_PORTS` selects a register file that has a spare read port and a spare write port, and in that case the clash cannot occur. The second hazard is a same-cycle dependence. The FP instruction reads the destination of an FP load that sits in the integer slot of the same pair. The block is purely combinational. The queue consumes `deq_cnt` entries, so a held FP instruction becomes the oldest entry in the next cycle and is evaluated again against its new younger neighbour.

Top module: `dual_issue_pair`

## Requirements
- R1: When `rdy_i` is 0, `iss0` and `iss1` are both 0 and `deq_cnt` is 0, whatever the slot contents.
- R2: When `rdy_i` is 1 and `s0_vld` is 1, `iss0` is 1. This includes the case where slot 1 is empty.
- R3: `iss1` is 1 only when `rdy_i`, `s0_vld` and `s1_vld` are 1, `s0_cls` is integer (0), `s1_cls` is floating-point (1), and neither `port_clash` nor `load_dep` is 1.
- R4: Every class pattern other than integer-then-FP (INT/INT, FP/FP, FP/INT) issues only the oldest entry, so `deq_cnt` is 1.
- R5: With `EXTRA_FP_PORTS`=0, `port_clash` is 1 exactly when an integer-then-FP pair is present and `s0_sub` is FP load (1), FP store (2) or register-set move (3). `iss1` is then 0. With `EXTRA_FP_PORTS`=1, `port_clash` is always 0.
- R6: `load_dep` is 1 exactly when an integer-then-FP pair is present, `s0_sub` is FP load (1), and `s1_srca` or `s1_srcb` equals `s0_dst`. `iss1` is then 0.
- R7: Issue is in order: `iss1` is never 1 while `iss0` is 0.
- R8: `deq_cnt` equals the number of issue strobes that are asserted.
- R9: When `s0_vld` is 0, nothing issues, even if slot 1 is valid. An FP instruction in the oldest slot issues alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdy_i | input | 1 | Downstream can accept instructions this cycle |
| s0_vld | input | 1 | Oldest slot holds an instruction |
| s0_cls | input | 1 | Oldest slot class: 0 integer, 1 floating-point |
| s0_sub | input | 2 | Oldest slot subclass: 0 plain, 1 FP load, 2 FP store, 3 register-set move |
| s0_dst | input | REG_W | Destination register index of the oldest slot |
| s1_vld | input | 1 | Younger slot holds an instruction |
| s1_cls | input | 1 | Younger slot class: 0 integer, 1 floating-point |
| s1_srca | input | REG_W | First source register of the younger slot |
| s1_srcb | input | REG_W | Second source register of the younger slot |
| iss0 | output | 1 | Oldest slot issues |
| iss1 | output | 1 | Younger slot issues |
| deq_cnt | output | 2 | Number of entries issued (0, 1 or 2) |
| port_clash | output | 1 | FP register-port contention in an integer-then-FP pair |
| load_dep | output | 1 | FP slot reads the FP load destination of the integer slot |

## Verification
The bench targets these corner cases:
- A pair that is blocked only by the port clash. A design that missed it would issue both instructions and oversubscribe the FP register ports.
- A pair that is blocked only by the load dependence, with the wide register-file variant and a match on either source. A design that missed it would let the FP instruction read a stale register.
- A valid younger entry behind an empty oldest slot, and a held FP instruction that has moved to the oldest slot. A wrong design would issue out of order or pair FP-then-integer.
- `rdy_i` low with a perfect pair, and random mixes with narrow register indices to force matches. A mismatch between `deq_cnt` and the strobes would drop or duplicate queue entries.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    typedef enum logic {
        CLS_INT = 1'b0,
        CLS_FP  = 1'b1
    } iclass_e;

    typedef enum logic [1:0] {
        SUB_PLAIN  = 2'd0,
        SUB_FPLOAD = 2'd1,
        SUB_FPSTOR = 2'd2,
        SUB_XMOVE  = 2'd3
    } isub_e;

    typedef struct packed {
        logic pattern;
        logic clash;
        logic dep;
    } pair_eval_t;

    function automatic logic uses_fp_port(isub_e s);
        return (s == SUB_FPLOAD) || (s == SUB_FPSTOR) || (s == SUB_XMOVE);
    endfunction

    function automatic logic int_then_fp(logic v0, iclass_e c0, logic v1, iclass_e c1);
        return v0 && v1 && (c0 == CLS_INT) && (c1 == CLS_FP);
    endfunction

endpackage

// File: rtl/di_pair_eval.sv
module di_pair_eval
    import dual_issue_pkg::*;
#(
    parameter int REG_W          = 5,
    parameter int EXTRA_FP_PORTS = 0
) (
    input  logic             v0,
    input  iclass_e          c0,
    input  isub_e            sub0,
    input  logic [REG_W-1:0] dst0,
    input  logic             v1,
    input  iclass_e          c1,
    input  logic [REG_W-1:0] srca1,
    input  logic [REG_W-1:0] srcb1,
    output pair_eval_t       ev
);

    logic pat;
    logic clash;
    logic src_hit;

    assign pat     = int_then_fp(v0, c0, v1, c1);
    assign src_hit = (srca1 == dst0) || (srcb1 == dst0);

    generate
        if (EXTRA_FP_PORTS != 0) begin : g_wide_rf
            assign clash = 1'b0;
        end else begin : g_shared_rf
            assign clash = pat && uses_fp_port(sub0);
        end
    endgenerate

    assign ev.pattern = pat;
    assign ev.clash   = clash;
    assign ev.dep     = pat && (sub0 == SUB_FPLOAD) && src_hit;

    // R5: a clash can only come from a slot-0 instruction that touches the FP ports
    always_comb begin
        assert_clash_src_R5: assert (!clash || (c0 == CLS_INT && sub0 != SUB_PLAIN));
    end

endmodule

// File: rtl/di_issue_sel.sv
module di_issue_sel
    import dual_issue_pkg::*;
(
    input  logic       rdy,
    input  logic       v0,
    input  pair_eval_t ev,
    output logic       iss0,
    output logic       iss1,
    output logic [1:0] cnt
);

    logic go;

    assign go   = rdy && v0;
    assign iss0 = go;
    assign iss1 = go && ev.pattern && !ev.clash && !ev.dep;
    assign cnt  = {1'b0, iss0} + {1'b0, iss1};

    always_comb begin
        assert_idle_R1:     assert (rdy || (!iss0 && !iss1));
        assert_in_order_R7: assert (!iss1 || iss0);
        assert_count_R8:    assert (cnt <= 2'd2 && (cnt == 2'd0) == !iss0);
        assert_hazard_R3:   assert (!iss1 || (ev.pattern && !ev.clash && !ev.dep));
    end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dual_issue_pkg::*;
#(
    parameter int REG_W          = 5,
    parameter int EXTRA_FP_PORTS = 0
) (
    input  logic             rdy_i,
    input  logic             s0_vld,
    input  logic             s0_cls,
    input  logic [1:0]       s0_sub,
    input  logic [REG_W-1:0] s0_dst,
    input  logic             s1_vld,
    input  logic             s1_cls,
    input  logic [REG_W-1:0] s1_srca,
    input  logic [REG_W-1:0] s1_srcb,
    output logic             iss0,
    output logic             iss1,
    output logic [1:0]       deq_cnt,
    output logic             port_clash,
    output logic             load_dep
);

    pair_eval_t ev;

    di_pair_eval #(
        .REG_W          (REG_W),
        .EXTRA_FP_PORTS (EXTRA_FP_PORTS)
    ) u_eval (
        .v0    (s0_vld),
        .c0    (iclass_e'(s0_cls)),
        .sub0  (isub_e'(s0_sub)),
        .dst0  (s0_dst),
        .v1    (s1_vld),
        .c1    (iclass_e'(s1_cls)),
        .srca1 (s1_srca),
        .srcb1 (s1_srcb),
        .ev    (ev)
    );

    di_issue_sel u_sel (
        .rdy  (rdy_i),
        .v0   (s0_vld),
        .ev   (ev),
        .iss0 (iss0),
        .iss1 (iss1),
        .cnt  (deq_cnt)
    );

    assign port_clash = ev.clash;
    assign load_dep   = ev.dep;

    // R9: the younger slot never issues behind an empty oldest slot
    always_comb begin
        assert_no_skip_R9: assert (s0_vld || (!iss0 && !iss1 && deq_cnt == 2'd0));
    end

endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;

    localparam int RW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rdy, v0, c0, v1, c1;
    logic [1:0]    sub0;
    logic [RW-1:0] d0, sa, sb;
    logic          a_i0, a_i1, a_pc, a_ld, b_i0, b_i1, b_pc, b_ld;
    logic [1:0]    a_cnt, b_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    dual_issue_pair #(.REG_W(RW), .EXTRA_FP_PORTS(0)) u0 (
        .rdy_i(rdy), .s0_vld(v0), .s0_cls(c0), .s0_sub(sub0), .s0_dst(d0),
        .s1_vld(v1), .s1_cls(c1), .s1_srca(sa), .s1_srcb(sb),
        .iss0(a_i0), .iss1(a_i1), .deq_cnt(a_cnt), .port_clash(a_pc), .load_dep(a_ld));

    dual_issue_pair #(.REG_W(RW), .EXTRA_FP_PORTS(1)) u1 (
        .rdy_i(rdy), .s0_vld(v0), .s0_cls(c0), .s0_sub(sub0), .s0_dst(d0),
        .s1_vld(v1), .s1_cls(c1), .s1_srca(sa), .s1_srcb(sb),
        .iss0(b_i0), .iss1(b_i1), .deq_cnt(b_cnt), .port_clash(b_pc), .load_dep(b_ld));

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Expected values computed from the requirements
    task automatic check_all(string tag);
        bit pat, pc0, dep, e0, e1a, e1b;
        pat = v0 && v1 && !c0 && c1;
        pc0 = pat && (sub0 != 2'd0);
        dep = pat && (sub0 == 2'd1) && ((sa == d0) || (sb == d0));
        e0  = rdy && v0;
        e1a = e0 && pat && !pc0 && !dep;
        e1b = e0 && pat && !dep;
        chk({tag, " R2 iss0"},      a_i0, e0);
        chk({tag, " R3 iss1"},      a_i1, e1a);
        chk({tag, " R8 cnt"},       a_cnt, int'(e0) + int'(e1a));
        chk({tag, " R5 clash"},     a_pc, pc0);
        chk({tag, " R6 dep"},       a_ld, dep);
        chk({tag, " R5 wide clash"}, b_pc, 0);
        chk({tag, " R6 wide iss1"}, b_i1, e1b);
        chk({tag, " R8 wide cnt"},  b_cnt, int'(e0) + int'(e1b));
    endtask

    task automatic apply(bit r, bit xv0, bit xc0, logic [1:0] xs, int xd,
                         bit xv1, bit xc1, int xa, int xb);
        @(negedge clk);
        rdy = r; v0 = xv0; c0 = xc0; sub0 = xs; d0 = RW'(xd);
        v1 = xv1; c1 = xc1; sa = RW'(xa); sb = RW'(xb);
        #2;
    endtask

    initial begin
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 idle iss0", a_i0, 0);
        chk("R1 idle cnt", a_cnt, 0);
        // R1: ready low with a clean integer-then-FP pair
        apply(0, 1, 0, 0, 3, 1, 1, 4, 5);
        chk("R1 stalled iss0", a_i0, 0);
        chk("R1 stalled iss1", a_i1, 0);
        chk("R1 stalled cnt", a_cnt, 0);
        // R3: clean pair issues both
        apply(1, 1, 0, 0, 3, 1, 1, 4, 5);
        chk("R3 pair cnt", a_cnt, 2);
        // R2: only the oldest valid
        apply(1, 1, 1, 0, 3, 0, 1, 4, 5);
        chk("R2 single cnt", a_cnt, 1);
        // R4: INT/INT, FP/FP, FP/INT
        apply(1, 1, 0, 0, 3, 1, 0, 4, 5);  chk("R4 int-int cnt", a_cnt, 1);
        apply(1, 1, 1, 0, 3, 1, 1, 4, 5);  chk("R4 fp-fp cnt", a_cnt, 1);
        apply(1, 1, 1, 0, 3, 1, 0, 4, 5);  chk("R4 fp-int cnt", a_cnt, 1);
        // R5: each FP-port subclass, no source match
        for (int s = 1; s < 4; s++) begin
            apply(1, 1, 0, 2'(s), 7, 1, 1, 4, 5);
            chk("R5 clash flag", a_pc, 1);
            chk("R5 clash iss1", a_i1, 0);
            chk("R5 wide iss1", b_i1, 1);
        end
        // R6: load dependence on either source, wide variant
        apply(1, 1, 0, 1, 9, 1, 1, 9, 2);
        chk("R6 srca dep", b_ld, 1);  chk("R6 srca iss1", b_i1, 0);
        apply(1, 1, 0, 1, 9, 1, 1, 2, 9);
        chk("R6 srcb dep", b_ld, 1);  chk("R6 srcb cnt", b_cnt, 1);
        apply(1, 1, 0, 2, 9, 1, 1, 9, 9);
        chk("R6 store no dep", b_ld, 0);
        // R9: empty oldest slot, valid younger
        apply(1, 0, 0, 0, 0, 1, 1, 1, 2);
        chk("R9 skip iss1", a_i1, 0);  chk("R9 skip cnt", a_cnt, 0);
        // R9: held FP becomes oldest, new younger is FP -> alone
        apply(1, 1, 0, 1, 6, 1, 1, 6, 1);
        chk("R9 held first cnt", a_cnt, 1);
        apply(1, 1, 1, 0, 6, 1, 1, 3, 3);
        chk("R9 held fp oldest cnt", a_cnt, 1);
        chk("R9 held fp oldest iss1", a_i1, 0);
        // R7/R8: constrained random with narrow register indices
        void'($urandom(32'd4242));
        for (int k = 0; k < 400; k++) begin
            apply(($urandom % 5) != 0, ($urandom % 6) != 0, $urandom % 2,
                  2'($urandom % 4), $urandom % 4, ($urandom % 5) != 0,
                  ($urandom % 3) != 0, $urandom % 4, $urandom % 4);
            check_all("rand");
            chk("R7 order", int'(a_i1 && !a_i0), 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule